// File: doc/BRIEF.md
# Capsule Group Readout Scheduler

This block sequences in-pixel convolution over a sensor array that is divided into non-overlapping 3×3 capsules. Capsules are handled in groups of three capsule rows, which are read together through three column readout paths. A full convolution for one output channel takes four steps, and each step computes a quarter of the outputs. Each step takes two exposures, one for the positive weights and one for the negative weights, so a frame holds eight counted sweeps over all groups.

The groups are read in a rolling order. Each read slot lasts a programmable number of clock cycles. As soon as a group's slot ends, the next group's read enable rises, and in that same cycle the finished group enters its reset window, followed by its exposure window. A group is read again only after all the other groups have been read. That interval must therefore cover the reset and the longest exposure. The check on this is made when start is requested, and an illegal setting is refused with an error flag.

Before the counted sweeps, one priming sweep runs with the ADC strobe held low. Its purpose is that every counted readout sees a full reset and exposure. The block has no data stream. All pins are plain control and status levels or pulses, so there is no valid/ready back-pressure.

Top module: `capsule_group_sched`

## Requirements
- R1: After reset, busy, cfg_err, frame_done, adc_strobe and sign_neg are 0, and step, rd_idx and all bits of rd_en, rst_en and expo_en are 0.
- R2: A start pulse while idle with a legal setting raises busy in the next cycle, with group 0 read first and cfg_err cleared.
- R3: While busy, exactly one bit of rd_en is high and rd_idx gives its position; while idle, rd_en is all zero and rd_idx is 0.
- R4: Each read slot lasts t_rd cycles, and the groups are read in ascending order from 0 to num_groups−1, then wrap to 0.
- R5: A frame has one priming sweep, then eight counted sweeps; in counted sweep p (0..7), step = p/2 and sign_neg = p mod 2 (0 = positive pass first), and step and sign_neg are 0 during priming and idle.
- R6: adc_strobe is high in the last cycle of every read slot of the counted sweeps and nowhere else, giving 8·num_groups strobes per frame.
- R7: rst_en[g] rises in the cycle right after group g's read slot ends (the cycle in which the next group's read enable rises) and stays high for t_rst cycles.
- R8: expo_en[g] is high for the t_expo cycles that follow group g's reset window, and not at all when t_expo is 0; rst_en[g] and expo_en[g] are never high together.
- R9: A start while idle is refused and cfg_err is set if num_groups < 2, num_groups > MAX_GROUPS, t_rd = 0, t_rst = 0, or (num_groups−1)·t_rd ≤ t_rst + t_expo. cfg_err then holds until a start is accepted.
- R10: frame_done is a one-cycle pulse in the cycle after the last slot of step 3's negative sweep, and busy falls in that same cycle.
- R11: A start pulse while busy is ignored.
- R12: num_groups, t_rd, t_rst and t_expo are captured when start is accepted; changing them during a frame has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a frame |
| num_groups | input | CNT_W | Groups per sweep |
| t_rd | input | DUR_W | Read slot length in cycles |
| t_rst | input | DUR_W | Reset window length in cycles |
| t_expo | input | DUR_W | Maximum exposure window in cycles |
| busy | output | 1 | Frame in progress |
| cfg_err | output | 1 | Last start was refused for an illegal setting |
| rd_en | output | MAX_GROUPS | One-hot group read enable |
| rd_idx | output | IDX_W | Index of the group being read |
| rst_en | output | MAX_GROUPS | Per-group reset window |
| expo_en | output | MAX_GROUPS | Per-group exposure window |
| step | output | 2 | Convolution step 0..3 |
| sign_neg | output | 1 | 1 during the negative-weight sweep |
| adc_strobe | output | 1 | Sample strobe toward the column converters |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench builds the block with MAX_GROUPS = 4 and DUR_W = 6. With these values a five-group request is representable on the num_groups port, so the over-limit refusal can be reached, and every frame is short enough to compare cycle by cycle against a model of slots, sweeps and per-group windows. The configurations cover the exact boundary (num_groups−1)·t_rd = t_rst + t_expo, one-cycle read slots with back-to-back strobes, a zero exposure, and the two-group minimum with long slots.

// File: rtl/cgs_pkg.sv
package cgs_pkg;
  localparam int NUM_STEPS  = 4;
  localparam int NUM_SIGNS  = 2;
  localparam int NUM_SWEEPS = NUM_STEPS * NUM_SIGNS;
  localparam int SWEEP_W    = $clog2(NUM_SWEEPS);

  typedef enum logic [1:0] {
    TMR_IDLE = 2'd0,
    TMR_RST  = 2'd1,
    TMR_EXP  = 2'd2
  } tmr_state_e;
endpackage

// File: rtl/cgs_cfg_check.sv
module cgs_cfg_check #(
  parameter int MAX_GROUPS = 8,
  parameter int DUR_W      = 8,
  parameter int CNT_W      = 4
) (
  input  logic [CNT_W-1:0] num_groups,
  input  logic [DUR_W-1:0] t_rd,
  input  logic [DUR_W-1:0] t_rst,
  input  logic [DUR_W-1:0] t_expo,
  output logic             cfg_ok
);
  localparam int PROD_W = CNT_W + DUR_W;

  logic [PROD_W-1:0] gap_cycles;
  logic [DUR_W:0]    need_cycles;
  logic              count_ok;

  always_comb begin
    count_ok    = (num_groups >= CNT_W'(2)) && (num_groups <= CNT_W'(MAX_GROUPS));
    need_cycles = {1'b0, t_rst} + {1'b0, t_expo};
    gap_cycles  = '0;
    if (count_ok)
      gap_cycles = PROD_W'(num_groups - CNT_W'(1)) * PROD_W'(t_rd);
    cfg_ok = count_ok && (t_rd != '0) && (t_rst != '0) &&
             (gap_cycles > PROD_W'(need_cycles));
  end
endmodule

// File: rtl/cgs_sequencer.sv
module cgs_sequencer
  import cgs_pkg::*;
#(
  parameter int DUR_W = 8,
  parameter int CNT_W = 4,
  parameter int IDX_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               cfg_ok,
  input  logic [CNT_W-1:0]   num_groups,
  input  logic [DUR_W-1:0]   t_rd,
  input  logic [DUR_W-1:0]   t_rst,
  input  logic [DUR_W-1:0]   t_expo,
  output logic               busy,
  output logic               cfg_err,
  output logic               priming,
  output logic [SWEEP_W-1:0] sweep,
  output logic [IDX_W-1:0]   grp,
  output logic               slot_last,
  output logic               frame_done,
  output logic [DUR_W-1:0]   trst_q,
  output logic [DUR_W-1:0]   texpo_q
);
  logic [CNT_W-1:0] num_q;
  logic [DUR_W-1:0] trd_q;
  logic [DUR_W-1:0] cnt_q;
  logic             accept, refuse, last_grp, last_sweep;

  assign accept     = start && !busy && cfg_ok;
  assign refuse     = start && !busy && !cfg_ok;
  assign slot_last  = busy && (cnt_q == trd_q - DUR_W'(1));
  assign last_grp   = (CNT_W'(grp) == num_q - CNT_W'(1));
  assign last_sweep = !priming && (sweep == SWEEP_W'(NUM_SWEEPS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      cfg_err    <= 1'b0;
      priming    <= 1'b0;
      sweep      <= '0;
      grp        <= '0;
      cnt_q      <= '0;
      frame_done <= 1'b0;
      num_q      <= '0;
      trd_q      <= '0;
      trst_q     <= '0;
      texpo_q    <= '0;
    end else begin
      frame_done <= 1'b0;
      if (accept) begin
        busy    <= 1'b1;
        cfg_err <= 1'b0;
        priming <= 1'b1;
        sweep   <= '0;
        grp     <= '0;
        cnt_q   <= '0;
        num_q   <= num_groups;
        trd_q   <= t_rd;
        trst_q  <= t_rst;
        texpo_q <= t_expo;
      end else if (refuse) begin
        cfg_err <= 1'b1;
      end else if (busy) begin
        if (slot_last) begin
          cnt_q <= '0;
          if (last_grp) begin
            grp <= '0;
            if (priming) begin
              priming <= 1'b0;
            end else if (last_sweep) begin
              busy       <= 1'b0;
              frame_done <= 1'b1;
              sweep      <= '0;
            end else begin
              sweep <= sweep + SWEEP_W'(1);
            end
          end else begin
            grp <= grp + IDX_W'(1);
          end
        end else begin
          cnt_q <= cnt_q + DUR_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/cgs_group_timer.sv
module cgs_group_timer
  import cgs_pkg::*;
#(
  parameter int DUR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic [DUR_W-1:0] t_rst,
  input  logic [DUR_W-1:0] t_expo,
  output logic             rst_o,
  output logic             expo_o
);
  tmr_state_e       state;
  logic [DUR_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= TMR_IDLE;
      cnt   <= '0;
    end else if (trig) begin
      state <= TMR_RST;
      cnt   <= '0;
    end else begin
      case (state)
        TMR_RST: begin
          if (cnt == t_rst - DUR_W'(1)) begin
            cnt   <= '0;
            state <= (t_expo == '0) ? TMR_IDLE : TMR_EXP;
          end else begin
            cnt <= cnt + DUR_W'(1);
          end
        end
        TMR_EXP: begin
          if (cnt == t_expo - DUR_W'(1)) begin
            cnt   <= '0;
            state <= TMR_IDLE;
          end else begin
            cnt <= cnt + DUR_W'(1);
          end
        end
        default: begin
          state <= TMR_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  assign rst_o  = (state == TMR_RST);
  assign expo_o = (state == TMR_EXP);
endmodule

// File: rtl/capsule_group_sched.sv
module capsule_group_sched
  import cgs_pkg::*;
#(
  parameter int  MAX_GROUPS = 8,
  parameter int  DUR_W      = 8,
  localparam int CNT_W      = $clog2(MAX_GROUPS + 1),
  localparam int IDX_W      = $clog2(MAX_GROUPS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [CNT_W-1:0]      num_groups,
  input  logic [DUR_W-1:0]      t_rd,
  input  logic [DUR_W-1:0]      t_rst,
  input  logic [DUR_W-1:0]      t_expo,
  output logic                  busy,
  output logic                  cfg_err,
  output logic [MAX_GROUPS-1:0] rd_en,
  output logic [IDX_W-1:0]      rd_idx,
  output logic [MAX_GROUPS-1:0] rst_en,
  output logic [MAX_GROUPS-1:0] expo_en,
  output logic [1:0]            step,
  output logic                  sign_neg,
  output logic                  adc_strobe,
  output logic                  frame_done
);
  logic               cfg_ok, priming, slot_last;
  logic [SWEEP_W-1:0] sweep;
  logic [IDX_W-1:0]   grp;
  logic [DUR_W-1:0]   trst_q, texpo_q;

  cgs_cfg_check #(
    .MAX_GROUPS(MAX_GROUPS), .DUR_W(DUR_W), .CNT_W(CNT_W)
  ) u_cfg (
    .num_groups(num_groups), .t_rd(t_rd), .t_rst(t_rst), .t_expo(t_expo),
    .cfg_ok(cfg_ok)
  );

  cgs_sequencer #(
    .DUR_W(DUR_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_ok(cfg_ok),
    .num_groups(num_groups), .t_rd(t_rd), .t_rst(t_rst), .t_expo(t_expo),
    .busy(busy), .cfg_err(cfg_err), .priming(priming), .sweep(sweep),
    .grp(grp), .slot_last(slot_last), .frame_done(frame_done),
    .trst_q(trst_q), .texpo_q(texpo_q)
  );

  for (genvar g = 0; g < MAX_GROUPS; g++) begin : g_group
    logic hit;
    assign hit      = (grp == IDX_W'(g));
    assign rd_en[g] = busy && hit;

    cgs_group_timer #(.DUR_W(DUR_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .trig(slot_last && hit),
      .t_rst(trst_q), .t_expo(texpo_q),
      .rst_o(rst_en[g]), .expo_o(expo_en[g])
    );
  end

  assign rd_idx     = grp;
  assign step       = sweep[SWEEP_W-1 -: 2];
  assign sign_neg   = sweep[0];
  assign adc_strobe = slot_last && !priming;
endmodule

// File: rtl/capsule_group_sched_chk.sv
module capsule_group_sched_chk #(
  parameter int MAX_GROUPS = 8,
  parameter int IDX_W      = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  busy,
  input logic                  cfg_err,
  input logic [MAX_GROUPS-1:0] rd_en,
  input logic [IDX_W-1:0]      rd_idx,
  input logic [MAX_GROUPS-1:0] rst_en,
  input logic [MAX_GROUPS-1:0] expo_en,
  input logic [1:0]            step,
  input logic                  adc_strobe,
  input logic                  frame_done
);
  assert_onehot_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $onehot(rd_en));
  assert_idle_no_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (rd_en == '0));
  assert_strobe_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    adc_strobe |-> busy);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (!busy && $past(busy)));
  assert_refused_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !busy);
  assert_step_at_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(step)) |-> (rd_idx == '0));

  for (genvar g = 0; g < MAX_GROUPS; g++) begin : g_chk
    assert_reset_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_en[g]) |-> rst_en[g]);
    assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(rst_en[g] && expo_en[g]));
  end
endmodule

bind capsule_group_sched capsule_group_sched_chk #(
  .MAX_GROUPS(MAX_GROUPS), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .cfg_err(cfg_err), .rd_en(rd_en),
  .rd_idx(rd_idx), .rst_en(rst_en), .expo_en(expo_en), .step(step),
  .adc_strobe(adc_strobe), .frame_done(frame_done)
);

// File: tb/capsule_group_sched_bench.sv
module capsule_group_sched_bench;
  localparam int MAXG     = 4;
  localparam int DW       = 6;
  localparam int CW       = $clog2(MAXG + 1);
  localparam int IW       = $clog2(MAXG);
  localparam int CLK_HALF = 5;
  localparam int NROWS    = 10;

  // columns: num_groups, t_rd, t_rst, t_expo, refused
  localparam int TBL [NROWS][5] = '{
    '{3, 4, 2, 5, 0},
    '{3, 4, 2, 6, 1},
    '{2, 9, 3, 5, 0},
    '{4, 1, 1, 1, 0},
    '{4, 3, 2, 0, 0},
    '{1, 10, 1, 1, 1},
    '{5, 4, 1, 1, 1},
    '{3, 0, 1, 1, 1},
    '{3, 5, 0, 1, 1},
    '{4, 2, 1, 4, 0}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [CW-1:0]   num_groups = '0;
  logic [DW-1:0]   t_rd = '0, t_rst = '0, t_expo = '0;
  logic            busy, cfg_err, sign_neg, adc_strobe, frame_done;
  logic [MAXG-1:0] rd_en, rst_en, expo_en;
  logic [IW-1:0]   rd_idx;
  logic [1:0]      step;

  int n_cmp = 0;
  int n_bad = 0;

  always #CLK_HALF clk = ~clk;

  capsule_group_sched #(.MAX_GROUPS(MAXG), .DUR_W(DW)) u_capsule_group_sched (
    .clk(clk), .rst_n(rst_n), .start(start), .num_groups(num_groups),
    .t_rd(t_rd), .t_rst(t_rst), .t_expo(t_expo), .busy(busy),
    .cfg_err(cfg_err), .rd_en(rd_en), .rd_idx(rd_idx), .rst_en(rst_en),
    .expo_en(expo_en), .step(step), .sign_neg(sign_neg),
    .adc_strobe(adc_strobe), .frame_done(frame_done)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_quiet(input string req);
    chk(req, "busy", int'(busy), 0);
    chk(req, "rd_en", int'(rd_en), 0);
    chk(req, "rd_idx", int'(rd_idx), 0);
    chk(req, "rst_en", int'(rst_en), 0);
    chk(req, "expo_en", int'(expo_en), 0);
    chk(req, "step", int'(step), 0);
    chk(req, "sign_neg", int'(sign_neg), 0);
    chk(req, "adc_strobe", int'(adc_strobe), 0);
    chk(req, "frame_done", int'(frame_done), 0);
  endtask

  task automatic pulse_start(input int n, input int rd, input int rs, input int ex);
    @(negedge clk);
    num_groups = CW'(n); t_rd = DW'(rd); t_rst = DW'(rs); t_expo = DW'(ex);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Full frame compared cycle by cycle; k = 0 is the first busy cycle.
  task automatic run_frame(input int n, input int rd, input int rs, input int ex,
                           input bit mid_start);
    int kfin, kend;
    kfin = 9 * n * rd;
    kend = kfin + rs + ex + 2;
    pulse_start(n, rd, rs, ex);
    // R12: scramble the settings once the frame is running
    num_groups = CW'(7); t_rd = DW'(1); t_rst = '0; t_expo = DW'(63);
    for (int k = 0; k <= kend; k++) begin
      int slot, swp, g, exp_rst, exp_exp;
      #1;
      if (k < kfin) begin
        slot = k / rd; swp = slot / n; g = slot % n;
        chk("R2", "busy", int'(busy), 1);
        chk("R3", "rd_en", int'(rd_en), 1 << g);
        chk("R4", "rd_idx", int'(rd_idx), g);
        chk("R5", "step", int'(step), (swp >= 1) ? (swp - 1) / 2 : 0);
        chk("R5", "sign_neg", int'(sign_neg), (swp >= 1) ? (swp - 1) % 2 : 0);
        chk("R6", "adc_strobe", int'(adc_strobe),
            ((swp >= 1) && (k % rd == rd - 1)) ? 1 : 0);
      end else begin
        chk("R10", "busy", int'(busy), 0);
        chk("R3", "rd_en", int'(rd_en), 0);
        chk("R3", "rd_idx", int'(rd_idx), 0);
        chk("R6", "adc_strobe", int'(adc_strobe), 0);
      end
      chk("R10", "frame_done", int'(frame_done), (k == kfin) ? 1 : 0);
      chk("R11", "cfg_err", int'(cfg_err), 0);
      exp_rst = 0; exp_exp = 0;
      for (int j = 0; j < 9 * n; j++) begin
        int e, d;
        e = (j + 1) * rd - 1;
        d = k - e;
        if (d >= 1 && d <= rs) exp_rst |= 1 << (j % n);
        else if (d > rs && d <= rs + ex) exp_exp |= 1 << (j % n);
      end
      chk("R7", "rst_en", int'(rst_en), exp_rst);
      chk("R8", "expo_en", int'(expo_en), exp_exp);
      @(negedge clk);
      if (mid_start && k == 20) start = 1'b1;
      if (k == 21) start = 1'b0;
    end
  endtask

  task automatic run_refused(input int n, input int rd, input int rs, input int ex);
    pulse_start(n, rd, rs, ex);
    for (int k = 0; k < 4; k++) begin
      #1;
      chk("R9", "cfg_err", int'(cfg_err), 1);
      chk("R9", "busy", int'(busy), 0);
      chk("R9", "rd_en", int'(rd_en), 0);
      chk("R9", "adc_strobe", int'(adc_strobe), 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check_quiet("R1");
    chk("R1", "cfg_err", int'(cfg_err), 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int r = 0; r < NROWS; r++) begin
      if (TBL[r][4] != 0)
        run_refused(TBL[r][0], TBL[r][1], TBL[r][2], TBL[r][3]);
      else
        run_frame(TBL[r][0], TBL[r][1], TBL[r][2], TBL[r][3], 1'b0);
    end

    // R11: an extra start in the middle of a frame changes nothing
    run_frame(3, 4, 2, 5, 1'b1);

    // R9: refusal right at the boundary, then the flag clears on acceptance (R2)
    run_refused(2, 4, 2, 2);
    run_frame(2, 5, 2, 2, 1'b0);

    // R1: reset in the middle of a frame returns everything to idle
    pulse_start(4, 3, 1, 2);
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    #1;
    check_quiet("R1");
    chk("R1", "cfg_err", int'(cfg_err), 0);
    rst_n = 1'b1;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule